// File: doc/BRIEF.md
# Pulse-Programmable Watchdog Supervisor

This block supervises a microcontroller. It drives one active-low reset line. The line goes low for two reasons: the power-good input is low, or the processor stopped servicing its watchdog. The processor services the watchdog through a single refresh line. A short high pulse restarts the watchdog count. After each reset, the first long pulse sets a new timeout. The block measures the width of that pulse in time-base ticks and uses the result as the timeout. From then on the timeout is locked until the next reset. Holding the refresh line high for too long counts as a failure, in the same way as missing a refresh.

All timing is counted in ticks of an external time-base strobe, which would typically be 1 µs. Power-good arrives already digitized. It also acts as the block's asynchronous clear. Refresh and inhibit are asynchronous to the clock and pass through a synchronizer. Refresh edges are detected after the synchronizer. While the inhibit input is high, a watchdog trip does not pull reset low, which is useful during software bring-up. Power-good still resets the processor while inhibit is high.

Top module: `wdg_supervisor`

## Requirements
- R1: Whenever `pwr_good_i` is low, `rst_n_o` is low, with no clock edge needed.
- R2: After power-good rises, and after every unblocked watchdog trip, `rst_n_o` stays low for exactly RST_HOLD_TICKS ticks and then goes high.
- R3: The watchdog count advances by one per tick only while the synchronized refresh is low. With tick high every cycle and two synchronizer stages, a timeout occurs `reload`+3 cycles after the refresh pin falls, or `reload` cycles after reset releases if no refresh comes.
- R4: A refresh high pulse of at least MIN_REFRESH_TICKS ticks restarts the count from zero when it falls, so regular pulses keep `rst_n_o` high.
- R5: After each reset, the first refresh pulse whose width W satisfies TICKS_PER_MS < W < MAX_TICKS sets `reload` to W. Any later pulse leaves `reload` unchanged until the next reset. Pulses with W ≤ TICKS_PER_MS neither set `reload` nor lock it.
- R6: Every reset returns `reload` to MAX_TICKS and clears the count.
- R7: When the count reaches `reload` before a refresh arrives, the block trips and `rst_n_o` goes low.
- R8: If refresh stays high until its measured width reaches `reload`, the block trips. With a rise at the pin and tick high every cycle, `rst_n_o` goes low `reload`+2 cycles later.
- R9: While the synchronized inhibit is high, neither kind of trip pulls `rst_n_o` low, and a count expiry only restarts the count. Power-good low still resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| tick_i | input | 1 | Time-base strobe; each high cycle is one tick |
| pwr_good_i | input | 1 | Digitized power-good; low is an asynchronous clear |
| refresh_i | input | 1 | Asynchronous refresh / timeout-programming line |
| inhibit_i | input | 1 | Asynchronous inhibit for watchdog-caused resets |
| rst_n_o | output | 1 | Active-low reset to the microcontroller |

## Verification
The bench sweeps every first-pulse width from one tick up to one below the maximum. It checks the exact cycle of each following timeout, so a design that gets the programming window wrong at the TICKS_PER_MS boundary, or that is off by one in the count or the synchronizer latency, shows up as a wrong delay. Each sweep point also runs a second timeout after the reset. This catches a design that keeps the programmed value across reset. Separate cases check that a second long pulse cannot reprogram the timeout, while earlier short pulses do not lock it. They also check a refresh held high against both the default and a programmed timeout. Finally they check that inhibit absorbs a trip and restarts the count rather than freezing it.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   // Events derived from one synchronized level
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } wdg_edge_t;

   // Reason for a watchdog trip in the current cycle
   typedef enum logic [1:0] {
      TRIP_NONE   = 2'd0,
      TRIP_EXPIRE = 2'd1,
      TRIP_HELD   = 2'd2
   } wdg_trip_e;

   // Reset output sequencer state
   typedef enum logic {
      RG_HOLD = 1'b0,
      RG_RUN  = 1'b1
   } wdg_rg_state_e;

endpackage

// File: rtl/wdg_sync.sv
module wdg_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("wdg_sync: STAGES must be at least 1");
   end

   if (STAGES == 1) begin : g_single
      logic [WIDTH-1:0] one_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
         if (!arst_ni) one_q <= '0;
         else          one_q <= d_i;
      end
      assign q_o = one_q;
   end else begin : g_chain
      logic [STAGES-1:0][WIDTH-1:0] chain_q;
      always_ff @(posedge clk_i or negedge arst_ni) begin
         if (!arst_ni) chain_q <= '0;
         else          chain_q <= {chain_q[STAGES-2:0], d_i};
      end
      assign q_o = chain_q[STAGES-1];
   end

endmodule

// File: rtl/wdg_pulse_meas.sv
module wdg_pulse_meas
   import wdg_pkg::*;
#(
   parameter int CNT_W   = 8,
   parameter int SAT_VAL = 255
) (
   input  logic             clk_i,
   input  logic             arst_ni,
   input  logic             clr_i,
   input  logic             lvl_i,
   input  logic             tick_i,
   output wdg_edge_t        ev_o,
   output logic [CNT_W-1:0] width_o,
   output logic [CNT_W-1:0] width_nxt_o
);

   localparam logic [CNT_W-1:0] SatLim = CNT_W'(SAT_VAL);

   logic             prev_q;
   logic [CNT_W-1:0] width_q;
   logic [CNT_W-1:0] width_nxt;

   assign ev_o.level = lvl_i;
   assign ev_o.rise  = lvl_i & ~prev_q;
   assign ev_o.fall  = ~lvl_i & prev_q;

   // Width counts ticks while high; the first tick is counted on the rise
   always_comb begin
      width_nxt = width_q;
      if (ev_o.rise) begin
         width_nxt = {{(CNT_W-1){1'b0}}, tick_i};
      end else if (lvl_i && tick_i && (width_q != SatLim)) begin
         width_nxt = width_q + {{(CNT_W-1){1'b0}}, 1'b1};
      end
   end

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         prev_q  <= 1'b0;
         width_q <= '0;
      end else begin
         prev_q  <= lvl_i;
         width_q <= clr_i ? '0 : width_nxt;
      end
   end

   assign width_o     = width_q;
   assign width_nxt_o = width_nxt;

endmodule

// File: rtl/wdg_reset_gen.sv
module wdg_reset_gen
   import wdg_pkg::*;
#(
   parameter int HOLD_TICKS = 100
) (
   input  logic clk_i,
   input  logic arst_ni,
   input  logic tick_i,
   input  logic trip_i,
   output logic rst_no
);

   localparam int HW = $clog2(HOLD_TICKS + 1);
   localparam logic [HW-1:0] LastHold = HW'(HOLD_TICKS - 1);

   wdg_rg_state_e    state_q;
   logic [HW-1:0]    hold_q;

   always_ff @(posedge clk_i or negedge arst_ni) begin
      if (!arst_ni) begin
         state_q <= RG_HOLD;
         hold_q  <= '0;
      end else begin
         case (state_q)
            RG_RUN: begin
               if (trip_i) begin
                  state_q <= RG_HOLD;
                  hold_q  <= '0;
               end
            end
            default: begin
               if (tick_i) begin
                  if (hold_q == LastHold) begin
                     state_q <= RG_RUN;
                     hold_q  <= '0;
                  end else begin
                     hold_q <= hold_q + {{(HW-1){1'b0}}, 1'b1};
                  end
               end
            end
         endcase
      end
   end

   assign rst_no = (state_q == RG_RUN);

endmodule

// File: rtl/wdg_supervisor.sv
module wdg_supervisor
   import wdg_pkg::*;
#(
   parameter int TICKS_PER_MS      = 1000,
   parameter int MAX_TICKS         = 10_000_000,
   parameter int MIN_REFRESH_TICKS = 1,
   parameter int RST_HOLD_TICKS    = 100,
   parameter int SYNC_STAGES       = 2
) (
   input  logic clk_i,
   input  logic tick_i,
   input  logic pwr_good_i,
   input  logic refresh_i,
   input  logic inhibit_i,
   output logic rst_n_o
);

   localparam int CNT_W = $clog2(MAX_TICKS + 1);
   localparam logic [CNT_W-1:0] MaxVal = CNT_W'(MAX_TICKS);
   localparam logic [CNT_W-1:0] MsVal  = CNT_W'(TICKS_PER_MS);
   localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_REFRESH_TICKS);

   // Elaboration-time parameter checks
   if (MAX_TICKS <= TICKS_PER_MS + 1) begin : g_bad_window
      $error("wdg_supervisor: MAX_TICKS must exceed TICKS_PER_MS + 1");
   end
   if (MIN_REFRESH_TICKS < 1 || MIN_REFRESH_TICKS > TICKS_PER_MS) begin : g_bad_min
      $error("wdg_supervisor: MIN_REFRESH_TICKS out of range");
   end
   if (RST_HOLD_TICKS < 1) begin : g_bad_hold
      $error("wdg_supervisor: RST_HOLD_TICKS must be at least 1");
   end

   logic [1:0]       sync_s;
   logic             refresh_s;
   logic             inhibit_s;
   logic             in_reset;
   logic             rst_n;
   wdg_edge_t        ref_ev;
   logic [CNT_W-1:0] width_q;
   logic [CNT_W-1:0] width_nxt;
   logic [CNT_W-1:0] elapsed_q;
   logic [CNT_W-1:0] reload_q;
   logic             locked_q;
   logic [CNT_W:0]   elapsed_inc;
   logic             refresh_ok;
   logic             program_ok;
   logic             count_en;
   logic             expire;
   logic             held;
   wdg_trip_e        cause;
   logic             wd_trip;

   wdg_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .arst_ni (pwr_good_i),
      .d_i     ({inhibit_i, refresh_i}),
      .q_o     (sync_s)
   );

   assign refresh_s = sync_s[0];
   assign inhibit_s = sync_s[1];
   assign in_reset  = ~rst_n;

   wdg_pulse_meas #(
      .CNT_W   (CNT_W),
      .SAT_VAL (MAX_TICKS)
   ) u_meas (
      .clk_i       (clk_i),
      .arst_ni     (pwr_good_i),
      .clr_i       (in_reset),
      .lvl_i       (refresh_s),
      .tick_i      (tick_i),
      .ev_o        (ref_ev),
      .width_o     (width_q),
      .width_nxt_o (width_nxt)
   );

   // Refresh acceptance and one-shot programming window
   assign refresh_ok = ~in_reset & ref_ev.fall & (width_q >= MinVal);
   assign program_ok = refresh_ok & ~locked_q & (width_q > MsVal) & (width_q < MaxVal);

   // Elapsed counter runs only while refresh is low
   assign elapsed_inc = {1'b0, elapsed_q} + {{CNT_W{1'b0}}, 1'b1};
   assign count_en    = ~in_reset & ~ref_ev.level & tick_i & ~refresh_ok;
   assign expire      = count_en & (elapsed_inc >= {1'b0, reload_q});
   assign held        = ~in_reset & ref_ev.level & tick_i & (width_nxt >= reload_q);

   always_comb begin
      cause = TRIP_NONE;
      if (expire)    cause = TRIP_EXPIRE;
      else if (held) cause = TRIP_HELD;
   end

   assign wd_trip = (cause != TRIP_NONE) & ~inhibit_s;

   always_ff @(posedge clk_i or negedge pwr_good_i) begin
      if (!pwr_good_i) begin
         elapsed_q <= '0;
         reload_q  <= MaxVal;
         locked_q  <= 1'b0;
      end else if (in_reset) begin
         elapsed_q <= '0;
         reload_q  <= MaxVal;
         locked_q  <= 1'b0;
      end else begin
         if (refresh_ok) begin
            elapsed_q <= '0;
         end else if (count_en) begin
            elapsed_q <= expire ? '0 : elapsed_inc[CNT_W-1:0];
         end
         if (program_ok) begin
            reload_q <= width_q;
            locked_q <= 1'b1;
         end
      end
   end

   wdg_reset_gen #(
      .HOLD_TICKS (RST_HOLD_TICKS)
   ) u_rgen (
      .clk_i   (clk_i),
      .arst_ni (pwr_good_i),
      .tick_i  (tick_i),
      .trip_i  (wd_trip),
      .rst_no  (rst_n)
   );

   assign rst_n_o = rst_n;

endmodule

// File: rtl/wdg_supervisor_chk.sv
module wdg_supervisor_chk #(
   parameter int MAX_TICKS      = 10_000_000,
   parameter int RST_HOLD_TICKS = 100,
   parameter int CNT_W          = 24
) (
   input logic             clk_i,
   input logic             pwr_good_i,
   input logic             tick_i,
   input logic             rst_n_o,
   input logic             inh_s,
   input logic             ref_s,
   input logic [CNT_W-1:0] elapsed,
   input logic [CNT_W-1:0] reload,
   input logic             locked
);

   localparam int LW = $clog2(RST_HOLD_TICKS + 2);
   localparam logic [LW-1:0] HoldVal = LW'(RST_HOLD_TICKS);

   logic [LW-1:0] low_ticks;

   always_ff @(posedge clk_i or negedge pwr_good_i) begin
      if (!pwr_good_i)                      low_ticks <= '0;
      else if (rst_n_o)                     low_ticks <= '0;
      else if (tick_i && low_ticks < HoldVal) low_ticks <= low_ticks + {{(LW-1){1'b0}}, 1'b1};
   end

   a_r1_pg_forces_reset: assert property (@(posedge clk_i)
      !pwr_good_i |-> !rst_n_o);

   a_r2_min_hold: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      $rose(rst_n_o) |-> low_ticks >= HoldVal);

   a_r3_frozen_while_high: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      ($past(pwr_good_i) && $past(ref_s) && $past(rst_n_o) && rst_n_o) |-> elapsed == $past(elapsed));

   a_r5_lock_kept: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      ($past(pwr_good_i) && rst_n_o && $past(rst_n_o) && $past(locked)) |-> locked);

   a_r6_reload_restored: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      (!rst_n_o && $past(!rst_n_o)) |-> reload == CNT_W'(MAX_TICKS));

   a_r7_count_below_reload: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      rst_n_o |-> elapsed < reload);

   a_r9_inhibit_blocks: assert property (@(posedge clk_i) disable iff (!pwr_good_i)
      ($past(pwr_good_i) && $fell(rst_n_o)) |-> !$past(inh_s));

endmodule

bind wdg_supervisor wdg_supervisor_chk #(
   .MAX_TICKS      (MAX_TICKS),
   .RST_HOLD_TICKS (RST_HOLD_TICKS),
   .CNT_W          (CNT_W)
) u_chk (
   .clk_i      (clk_i),
   .pwr_good_i (pwr_good_i),
   .tick_i     (tick_i),
   .rst_n_o    (rst_n_o),
   .inh_s      (inhibit_s),
   .ref_s      (refresh_s),
   .elapsed    (elapsed_q),
   .reload     (reload_q),
   .locked     (locked_q)
);

// File: tb/wdg_supervisor_tb.sv
module wdg_supervisor_tb;

   localparam int MS   = 8;
   localparam int MAXT = 120;
   localparam int HOLD = 5;

   logic clk = 1'b0;
   logic tick = 1'b1;
   logic pg = 1'b0;
   logic refresh = 1'b0;
   logic inhibit = 1'b0;
   logic rst_n;

   int checks = 0;
   int errors = 0;

   always #4 clk = ~clk;

   wdg_supervisor #(
      .TICKS_PER_MS      (MS),
      .MAX_TICKS         (MAXT),
      .MIN_REFRESH_TICKS (1),
      .RST_HOLD_TICKS    (HOLD),
      .SYNC_STAGES       (2)
   ) u_dut (
      .clk_i      (clk),
      .tick_i     (tick),
      .pwr_good_i (pg),
      .refresh_i  (refresh),
      .inhibit_i  (inhibit),
      .rst_n_o    (rst_n)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wait_low(output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (rst_n && cnt < 5000);
   endtask

   task automatic wait_high(output int cnt);
      cnt = 0;
      do begin
         @(negedge clk);
         cnt++;
      end while (!rst_n && cnt < 5000);
   endtask

   task automatic power_cycle();
      int c;
      @(negedge clk);
      pg = 1'b0;
      repeat (3) @(negedge clk);
      check(rst_n == 1'b0, "R1 power-good low", int'(rst_n), 0);
      pg = 1'b1;
      wait_high(c);
      check(c == HOLD, "R2 power-up hold", c, HOLD);
   endtask

   task automatic pulse(input int w);
      refresh = 1'b1;
      repeat (w) @(negedge clk);
      refresh = 1'b0;
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired for all requirements actual=%0d expected=%0d", 200000, 0);
      finish_run();
   end

   initial begin
      int n;
      int lows;
      repeat (3) @(negedge clk);
      check(rst_n == 1'b0, "R1 reset state", int'(rst_n), 0);

      // R3 R7: untouched watchdog times out at the default reload
      power_cycle();
      wait_low(n);
      check(n == MAXT, "R3 R7 default timeout", n, MAXT);
      wait_high(n);
      check(n == HOLD, "R2 hold after timeout", n, HOLD);

      // Sweep of first-pulse widths around both window edges
      for (int w = 1; w < MAXT; w++) begin
         int exp;
         power_cycle();
         pulse(w);
         wait_low(n);
         exp = (w > MS) ? w + 3 : MAXT + 3;
         if (w > MS) check(n == exp, "R5 programmed timeout", n, exp);
         else        check(n == exp, "R4 short refresh restart", n, exp);
         wait_high(n);
         check(n == HOLD, "R2 hold after trip", n, HOLD);
         wait_low(n);
         check(n == MAXT, "R6 reload restored", n, MAXT);
      end

      // R5: second long pulse must not reprogram
      power_cycle();
      pulse(20);
      repeat (4) @(negedge clk);
      pulse(15);
      wait_low(n);
      check(n == 23, "R5 lock after first program", n, 23);

      // R5: short pulses before do not lock
      power_cycle();
      pulse(3);
      repeat (4) @(negedge clk);
      pulse(30);
      wait_low(n);
      check(n == 33, "R5 short pulse leaves window open", n, 33);

      // R8: held refresh against default and programmed reload
      power_cycle();
      refresh = 1'b1;
      wait_low(n);
      refresh = 1'b0;
      check(n == MAXT + 2, "R8 held at default reload", n, MAXT + 2);
      power_cycle();
      pulse(20);
      repeat (5) @(negedge clk);
      refresh = 1'b1;
      wait_low(n);
      refresh = 1'b0;
      check(n == 22, "R8 held at programmed reload", n, 22);

      // R4: regular short refreshes keep reset high
      power_cycle();
      lows = 0;
      repeat (20) begin
         repeat (60) begin
            @(negedge clk);
            if (!rst_n) lows++;
         end
         pulse(1);
      end
      check(lows == 0, "R4 keep-alive", lows, 0);

      // R9: inhibited expiry restarts the count
      @(negedge clk);
      inhibit = 1'b1;
      power_cycle();
      lows = 0;
      repeat (200) begin
         @(negedge clk);
         if (!rst_n) lows++;
      end
      check(lows == 0, "R9 expiry blocked", lows, 0);
      inhibit = 1'b0;
      wait_low(n);
      check(n == 2 * MAXT - 200, "R9 count restarted on blocked expiry", n, 2 * MAXT - 200);

      // R9: power-good still resets under inhibit
      @(negedge clk);
      inhibit = 1'b1;
      power_cycle();
      @(negedge clk);
      pg = 1'b0;
      @(negedge clk);
      check(rst_n == 1'b0, "R9 power-good resets under inhibit", int'(rst_n), 0);

      // R9: held refresh blocked, then expiry at default reload
      power_cycle();
      refresh = 1'b1;
      lows = 0;
      repeat (200) begin
         @(negedge clk);
         if (!rst_n) lows++;
      end
      check(lows == 0, "R9 held trip blocked", lows, 0);
      refresh = 1'b0;
      @(negedge clk);
      inhibit = 1'b0;
      wait_low(n);
      check(n == MAXT + 2, "R9 R6 no program from overlong pulse", n, MAXT + 2);

      finish_run();
   end

endmodule